// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the coherence engine that sits beside a node's home memory in a clustered multiprocessor. For every memory block homed at this node it keeps a directory entry. The entry is a presence vector with one bit per cluster plus a state: uncached, clean or dirty. Requests arrive from clusters on a request channel, naming a block index. A block index is the byte address divided by the block size, 16 bytes by default. A request is either a shared read or a read for exclusive ownership. The controller looks up the entry and does one of three things. It replies with data from home memory, it forwards the request to the single cluster that holds a dirty copy, or it sends invalidations to the other sharers and replies once every one of them has acknowledged.

All outbound traffic leaves through one registered message channel with a valid/ready handshake. Replies, forwards, invalidations and retries each carry a kind code, a destination cluster, the original requester and the block index. Acknowledgements for invalidations, and completion notices from a forwarded owner, come back on a separate acknowledgement input. Only one invalidation or forward transaction is open at a time. Its block is held busy, and conflicting requests are told to retry. After reset the controller sweeps the directory store clean before it accepts any work.

Top module: `dirc_home`

## Requirements
- R1: After reset, req_ready stays low and no message is issued for exactly DEPTH cycles while every entry is cleared to uncached with no sharers. After that, a first read of any block is answered with data.
- R2: A read (req_excl=0) to an uncached or clean block is answered with kind 0 (shared data) sent to the requester, with msg_req equal to the requester and msg_blk equal to the request's block. The requester becomes a sharer and the block is clean.
- R3: A read to a block that another cluster holds dirty produces kind 2 (forward read) sent to the owner, with msg_req equal to the requester. After one acknowledgement for that block, the block is clean with both owner and requester as sharers.
- R4: A write (req_excl=1) to an uncached block is answered with kind 1 (exclusive data) to the requester. The block becomes dirty with the requester as its only holder.
- R5: A write to a clean block sends one kind 4 (invalidate) message to each sharer other than the requester, in ascending cluster number, each carrying the requester in msg_req. Kind 1 follows only after as many acknowledgements as invalidations have arrived. A requester that is the only sharer gets kind 1 at once.
- R6: A write to a block held dirty by another cluster produces kind 3 (forward write) to the owner. After its acknowledgement, the requester is the sole dirty holder. A request from the dirty owner itself gets kind 1 and leaves the entry unchanged.
- R7: A request to the block of the open transaction receives kind 5 (retry) and leaves its directory entry unchanged.
- R8: While a transaction is open, a request to another block that would need a forward or invalidations receives kind 5 and leaves its entry unchanged. A request to another block that needs neither is served normally.
- R9: While msg_ready is low, a pending message holds all its fields. Every message is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| req_excl | input | 1 | 1 = exclusive (write) request, 0 = shared read |
| req_src | input | $clog2(NCLU) | Requesting cluster |
| req_blk | input | $clog2(DEPTH) | Block index of the request |
| ack_valid | input | 1 | One acknowledgement (invalidation done or forwarded owner done) |
| ack_blk | input | $clog2(DEPTH) | Block the acknowledgement refers to |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Receiver takes the message |
| msg_kind | output | 3 | 0 shared data, 1 exclusive data, 2 forward read, 3 forward write, 4 invalidate, 5 retry |
| msg_dst | output | $clog2(NCLU) | Destination cluster |
| msg_req | output | $clog2(NCLU) | Original requester |
| msg_blk | output | $clog2(DEPTH) | Block index |

## Verification
The bench goes after the transitions that a wrong presence update would corrupt. A read of a dirty block must leave both the old owner and the reader as sharers, and a controller that dropped either one would skip an invalidation on the next write. It withholds the last acknowledgement of an invalidation round to catch an exclusive reply issued early, and it checks retries against both the busy block and an unrelated block that would need the single slot. A controller that let those through would lose or double-count acknowledgements. A long random mix over a few blocks, with random backpressure on the message channel, compares every message against an arithmetic model of the directory and would expose any lost or repeated message.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_CLN = 2'd1,
    ST_DRT = 2'd2
  } blk_st_e;

  typedef enum logic [2:0] {
    MK_DSH = 3'd0,
    MK_DEX = 3'd1,
    MK_FRD = 3'd2,
    MK_FWR = 3'd3,
    MK_INV = 3'd4,
    MK_NAK = 3'd5
  } msg_kind_e;

  typedef enum logic [2:0] {
    S_INIT = 3'd0,
    S_IDLE = 3'd1,
    S_LOOK = 3'd2,
    S_INV  = 3'd3,
    S_FIN  = 3'd4
  } fsm_e;

endpackage

// File: rtl/dirc_store.sv
module dirc_store #(
  parameter int DEPTH = 256,
  parameter int W     = 18,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/dirc_lowbit.sv
module dirc_lowbit #(
  parameter int N  = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         hit
);

  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = W'(i);
        hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dirc_pend.sv
module dirc_pend #(
  parameter int NCLU = 16,
  parameter int IW   = 8,
  localparam int CW  = $clog2(NCLU),
  localparam int NW  = $clog2(NCLU + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic [IW-1:0] a_idx,
  input  logic [NW-1:0] a_cnt,
  input  logic          a_excl,
  input  logic          a_fwd,
  input  logic [CW-1:0] a_req,
  input  logic [CW-1:0] a_own,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  input  logic          rel,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] p_idx,
  output logic          p_excl,
  output logic          p_fwd,
  output logic [CW-1:0] p_req,
  output logic [CW-1:0] p_own
);

  logic [NW-1:0] cnt_q;
  logic          ack_hit;

  assign ack_hit = ack_valid && (ack_idx == p_idx);
  assign done    = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      p_idx  <= '0;
      p_excl <= 1'b0;
      p_fwd  <= 1'b0;
      p_req  <= '0;
      p_own  <= '0;
    end else if (alloc) begin
      busy   <= 1'b1;
      cnt_q  <= a_cnt;
      p_idx  <= a_idx;
      p_excl <= a_excl;
      p_fwd  <= a_fwd;
      p_req  <= a_req;
      p_own  <= a_own;
    end else begin
      if (rel) busy <= 1'b0;
      if (busy && cnt_q != '0 && ack_hit) cnt_q <= cnt_q - NW'(1);
    end
  end

  // R7
  no_extra_ack_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !ack_hit);

  // R8
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !busy);

endmodule

// File: rtl/dirc_home.sv
module dirc_home
  import dirc_pkg::*;
#(
  parameter int NCLU  = 16,
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(NCLU),
  localparam int IW   = $clog2(DEPTH),
  localparam int NW   = $clog2(NCLU + 1),
  localparam int EW   = NCLU + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_excl,
  input  logic [CW-1:0] req_src,
  input  logic [IW-1:0] req_blk,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_blk,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [2:0]    msg_kind,
  output logic [CW-1:0] msg_dst,
  output logic [CW-1:0] msg_req,
  output logic [IW-1:0] msg_blk
);

  fsm_e st_q, st_d;

  logic [IW-1:0]   init_idx;
  logic            rq_excl;
  logic [CW-1:0]   rq_src;
  logic [IW-1:0]   rq_idx;
  logic [NCLU-1:0] inv_left, inv_d;

  logic            rd_en;
  logic [EW-1:0]   rd_data;
  logic            wr_en;
  logic [IW-1:0]   wr_idx;
  logic [EW-1:0]   wr_data;

  logic            alloc, rel;
  logic [NW-1:0]   a_cnt;
  logic            a_fwd;
  logic            p_busy, p_done, p_excl, p_fwd;
  logic [IW-1:0]   p_idx;
  logic [CW-1:0]   p_req, p_own;

  logic            ld;
  msg_kind_e       ld_kind;
  logic [CW-1:0]   ld_dst, ld_req;
  logic [IW-1:0]   ld_idx;

  blk_st_e         ent_st;
  logic [NCLU-1:0] ent_pr, src_bit, others, preq_bit, pown_bit;
  logic [CW-1:0]   own, inv_pick;
  logic            own_hit, inv_hit, same_blk, out_free, accept;

  assign ent_st   = blk_st_e'(rd_data[EW-1:EW-2]);
  assign ent_pr   = rd_data[NCLU-1:0];
  assign src_bit  = NCLU'(1) << rq_src;
  assign preq_bit = NCLU'(1) << p_req;
  assign pown_bit = NCLU'(1) << p_own;
  assign others   = ent_pr & ~src_bit;
  assign same_blk = p_busy && (p_idx == rq_idx);
  assign out_free = !msg_valid || msg_ready;

  assign req_ready = (st_q == S_IDLE) && !p_done;
  assign accept    = req_ready && req_valid;

  dirc_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk     (clk),
    .rd_en   (rd_en),
    .rd_idx  (req_blk),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  dirc_lowbit #(.N(NCLU)) u_owner (
    .vec (ent_pr),
    .idx (own),
    .hit (own_hit)
  );

  dirc_lowbit #(.N(NCLU)) u_invsel (
    .vec (inv_left),
    .idx (inv_pick),
    .hit (inv_hit)
  );

  dirc_pend #(.NCLU(NCLU), .IW(IW)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .alloc     (alloc),
    .a_idx     (rq_idx),
    .a_cnt     (a_cnt),
    .a_excl    (rq_excl),
    .a_fwd     (a_fwd),
    .a_req     (rq_src),
    .a_own     (own),
    .ack_valid (ack_valid),
    .ack_idx   (ack_blk),
    .rel       (rel),
    .busy      (p_busy),
    .done      (p_done),
    .p_idx     (p_idx),
    .p_excl    (p_excl),
    .p_fwd     (p_fwd),
    .p_req     (p_req),
    .p_own     (p_own)
  );

  always_comb begin
    st_d    = st_q;
    rd_en   = 1'b0;
    ld      = 1'b0;
    ld_kind = MK_NAK;
    ld_dst  = rq_src;
    ld_req  = rq_src;
    ld_idx  = rq_idx;
    wr_en   = 1'b0;
    wr_idx  = rq_idx;
    wr_data = '0;
    alloc   = 1'b0;
    a_cnt   = '0;
    a_fwd   = 1'b0;
    rel     = 1'b0;
    inv_d   = inv_left;
    case (st_q)
      S_INIT: begin
        wr_en  = 1'b1;
        wr_idx = init_idx;
        if (init_idx == IW'(DEPTH - 1)) st_d = S_IDLE;
      end
      S_IDLE: begin
        if (p_done) st_d = S_FIN;
        else if (req_valid) begin
          rd_en = 1'b1;
          st_d  = S_LOOK;
        end
      end
      S_LOOK: begin
        if (out_free) begin
          st_d = S_IDLE;
          ld   = 1'b1;
          if (same_blk) begin
            ld_kind = MK_NAK;
          end else if (ent_st == ST_DRT && own_hit) begin
            if (own == rq_src) begin
              ld_kind = MK_DEX;
            end else if (p_busy) begin
              ld_kind = MK_NAK;
            end else begin
              ld_kind = rq_excl ? MK_FWR : MK_FRD;
              ld_dst  = own;
              alloc   = 1'b1;
              a_cnt   = NW'(1);
              a_fwd   = 1'b1;
            end
          end else if (!rq_excl) begin
            ld_kind = MK_DSH;
            wr_en   = 1'b1;
            wr_data = {ST_CLN, ent_pr | src_bit};
          end else if (others == '0) begin
            ld_kind = MK_DEX;
            wr_en   = 1'b1;
            wr_data = {ST_DRT, src_bit};
          end else if (p_busy) begin
            ld_kind = MK_NAK;
          end else begin
            ld    = 1'b0;
            alloc = 1'b1;
            a_cnt = NW'($countones(others));
            inv_d = others;
            st_d  = S_INV;
          end
        end
      end
      S_INV: begin
        if (out_free && inv_hit) begin
          ld      = 1'b1;
          ld_kind = MK_INV;
          ld_dst  = inv_pick;
          inv_d   = inv_left & ~(NCLU'(1) << inv_pick);
          if (inv_d == '0) st_d = S_IDLE;
        end
      end
      S_FIN: begin
        ld_idx = p_idx;
        ld_req = p_req;
        ld_dst = p_req;
        wr_idx = p_idx;
        if (p_fwd) begin
          wr_en   = 1'b1;
          wr_data = p_excl ? {ST_DRT, preq_bit} : {ST_CLN, preq_bit | pown_bit};
          rel     = 1'b1;
          st_d    = S_IDLE;
        end else if (out_free) begin
          ld      = 1'b1;
          ld_kind = MK_DEX;
          wr_en   = 1'b1;
          wr_data = {ST_DRT, preq_bit};
          rel     = 1'b1;
          st_d    = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_INIT;
      init_idx <= '0;
      inv_left <= '0;
      rq_excl  <= 1'b0;
      rq_src   <= '0;
      rq_idx   <= '0;
    end else begin
      st_q     <= st_d;
      inv_left <= inv_d;
      if (st_q == S_INIT) init_idx <= init_idx + IW'(1);
      if (accept) begin
        rq_excl <= req_excl;
        rq_src  <= req_src;
        rq_idx  <= req_blk;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_kind  <= '0;
      msg_dst   <= '0;
      msg_req   <= '0;
      msg_blk   <= '0;
    end else if (ld) begin
      msg_valid <= 1'b1;
      msg_kind  <= ld_kind;
      msg_dst   <= ld_dst;
      msg_req   <= ld_req;
      msg_blk   <= ld_idx;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R9
  hold_msg_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dst)
                                && $stable(msg_req) && $stable(msg_blk));

  // R1
  quiet_init_chk: assert property (@(posedge clk) disable iff (rst)
    st_q == S_INIT |-> !msg_valid);

  // R5
  inv_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_kind == MK_INV |-> p_busy);

  // R3
  fwd_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && (msg_kind == MK_FRD || msg_kind == MK_FWR) |-> p_busy);

  // R4
  dirty_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[EW-1:EW-2] == ST_DRT |-> $countones(wr_data[NCLU-1:0]) == 1);

  // R2
  clean_shared_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[EW-1:EW-2] == ST_CLN |-> wr_data[NCLU-1:0] != '0);

endmodule

// File: tb/test_dirc_home.sv
module test_dirc_home;
  import dirc_pkg::*;

  localparam int NC = 16;
  localparam int DP = 256;
  localparam int CW = 4;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_excl  = 1'b0;
  logic [CW-1:0] req_src   = '0;
  logic [IW-1:0] req_blk   = '0;
  logic          ack_valid = 1'b0;
  logic [IW-1:0] ack_blk   = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [2:0]    msg_kind;
  logic [CW-1:0] msg_dst, msg_req;
  logic [IW-1:0] msg_blk;

  dirc_home i_dirc_home (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_excl(req_excl),
    .req_src(req_src), .req_blk(req_blk),
    .ack_valid(ack_valid), .ack_blk(ack_blk),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dst(msg_dst), .msg_req(msg_req), .msg_blk(msg_blk)
  );

  typedef struct packed {
    logic [2:0]    k;
    logic [CW-1:0] d;
    logic [CW-1:0] r;
    logic [IW-1:0] b;
  } msg_t;

  msg_t mq[$];
  int nchk = 0;
  int nfail = 0;
  bit bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [1:0]    mst [DP];
  logic [NC-1:0] mpr [DP];

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    msg_ready <= bp ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (!rst && msg_valid && msg_ready) mq.push_back({msg_kind, msg_dst, msg_req, msg_blk});
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic exp_msg(input int k, input int d, input int r, input int b, input string rq);
    msg_t m, e;
    int t = 0;
    e = {3'(k), CW'(d), CW'(r), IW'(b)};
    while (mq.size() == 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    nchk++;
    if (mq.size() == 0) begin
      nfail++;
      $display("FAIL %s message actual=none expected=kind %0d dst %0d req %0d blk %0d", rq, k, d, r, b);
    end else begin
      m = mq.pop_front();
      if (m != e) begin
        nfail++;
        $display("FAIL %s message actual=kind %0d dst %0d req %0d blk %0d expected=kind %0d dst %0d req %0d blk %0d",
                 rq, m.k, m.d, m.r, m.b, k, d, r, b);
      end
    end
  endtask

  task automatic send_req(input bit ex, input int s, input int b);
    @(negedge clk);
    req_valid = 1'b1;
    req_excl  = ex;
    req_src   = CW'(s);
    req_blk   = IW'(b);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_ack(input int b);
    @(negedge clk);
    ack_valid = 1'b1;
    ack_blk   = IW'(b);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  function automatic int lowb(input logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return 0;
  endfunction

  // full transaction against the bench model, network side answered at once
  task automatic txn(input bit ex, input int s, input int b);
    logic [NC-1:0] sb, oth;
    int own;
    sb = NC'(1) << s;
    send_req(ex, s, b);
    if (mst[b] == 2'd2) begin
      own = lowb(mpr[b]);
      if (own == s) begin
        exp_msg(MK_DEX, s, s, b, "R6");
      end else begin
        exp_msg(ex ? MK_FWR : MK_FRD, own, s, b, ex ? "R6" : "R3");
        send_ack(b);
        repeat (3) @(negedge clk);
        if (ex) begin
          mpr[b] = sb;
        end else begin
          mst[b] = 2'd1;
          mpr[b] = sb | (NC'(1) << own);
        end
      end
    end else if (!ex) begin
      exp_msg(MK_DSH, s, s, b, "R2");
      mst[b] = 2'd1;
      mpr[b] = mpr[b] | sb;
    end else begin
      oth = mpr[b] & ~sb;
      for (int c = 0; c < NC; c++) if (oth[c]) exp_msg(MK_INV, c, s, b, "R5");
      for (int c = 0; c < NC; c++) if (oth[c]) send_ack(b);
      if (oth != '0) repeat (3) @(negedge clk);
      exp_msg(MK_DEX, s, s, b, (mst[b] == 2'd0) ? "R4" : "R5");
      mst[b] = 2'd2;
      mpr[b] = sb;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int cyc;
    int seed;
    for (int b = 0; b < DP; b++) begin
      mst[b] = 2'd0;
      mpr[b] = '0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: clearing sweep
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk(!req_ready && !msg_valid, "R1", "busy after reset", int'(req_ready), 0);
    end while (!req_ready && cyc < 5000);
    chk(cyc == DP, "R1", "cycles until ready", cyc, DP);
    chk(mq.size() == 0, "R1", "messages during clear", mq.size(), 0);

    // R2 R4 R5 R3 R6 directed
    txn(0, 3, 0);
    txn(0, 7, 0);
    txn(1, 3, 0);
    txn(0, 9, 0);
    txn(1, 12, 0);
    txn(1, 4, 0);
    txn(1, 4, 0);
    txn(1, 6, 1);
    txn(1, 6, 1);
    txn(0, 2, 2);
    txn(1, 2, 2);
    txn(0, 15, 255);
    txn(0, 0, 255);
    txn(1, 15, 255);

    // R7 R8: open transaction on block 5
    txn(0, 1, 5);
    txn(0, 2, 5);
    txn(0, 3, 5);
    txn(1, 8, 6);
    send_req(1, 5, 5);
    exp_msg(MK_INV, 1, 5, 5, "R5");
    exp_msg(MK_INV, 2, 5, 5, "R5");
    exp_msg(MK_INV, 3, 5, 5, "R5");
    send_req(0, 7, 5);
    exp_msg(MK_NAK, 7, 7, 5, "R7");
    send_req(0, 4, 7);
    exp_msg(MK_DSH, 4, 4, 7, "R8");
    mst[7] = 2'd1;
    mpr[7] = NC'(1) << 4;
    send_req(1, 9, 6);
    exp_msg(MK_NAK, 9, 9, 6, "R8");
    send_req(1, 10, 8);
    exp_msg(MK_DEX, 10, 10, 8, "R8");
    mst[8] = 2'd2;
    mpr[8] = NC'(1) << 10;
    send_ack(5);
    send_ack(5);
    repeat (8) @(negedge clk);
    chk(mq.size() == 0, "R5", "early reply before last ack", mq.size(), 0);
    send_ack(5);
    repeat (3) @(negedge clk);
    exp_msg(MK_DEX, 5, 5, 5, "R5");
    mst[5] = 2'd2;
    mpr[5] = NC'(1) << 5;
    txn(0, 11, 6);
    txn(0, 7, 5);

    // R9 with R2..R6: random mix under backpressure
    seed = 32'h1234567;
    for (int i = 0; i < 400; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      bp = (i >= 200);
      txn(seed[0], int'(seed[4:1]), 32 + int'(seed[7:5]));
    end
    bp = 1'b0;
    repeat (10) @(negedge clk);
    chk(mq.size() == 0, "R9", "extra messages", mq.size(), 0);
    summary();
  end

endmodule